// File: doc/BRIEF.md
# Flag-Setting Integer Data-Processing ALU

This block is the integer execution unit of a processor datapath. It takes a first operand, a second operand that has already passed through the shift stage, a 4-bit operation code, a set-flags bit, the current condition flags and the carry-out of the shift stage. It produces a result word, a write-enable for the destination register and the next value of the four condition flags, ordered {N, Z, C, V}.

Sixteen operations are supported: bitwise AND, exclusive-OR, OR and bit-clear; move and move-inverted; add and add-with-carry; subtract, reverse subtract and their with-carry forms; and four flag-only forms (test, test-equivalence, compare, compare-negative). In subtraction the carry is an inverted borrow. The flag-only forms always update the flags and never request a write. When the `OUT_REG` parameter is 1 (the default), all outputs are registered and appear one clock after the inputs. When it is 0, the outputs are combinational.

Top module: `dp_alu`

## Requirements
- R1: The opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. ADD gives a+b and ADC gives a+b+C, both modulo 2^DATA_W, where C is flags_in[1].
- R2: SUB gives a-b. SBC gives a-b-NOT(C). For every subtracting form, the C flag is 1 exactly when no borrow occurred.
- R3: RSB gives b-a and RSC gives b-a-NOT(C). The operand order is swapped relative to SUB and SBC.
- R4: The logical and move results are: AND a&b, EOR a^b, ORR a|b, BIC a&~b, MOV b, MVN ~b. MOV and MVN ignore a.
- R5: TST, TEQ, CMP and CMN drive wr_en to 0 and update the flags whatever the value of set_flags. The result port carries a&b, a^b, a-b and a+b respectively.
- R6: Every other opcode drives wr_en to 1. When set_flags is 0, these opcodes pass flags_in through to flags_out unchanged.
- R7: When an arithmetic form updates the flags: N is the result MSB, Z is 1 for a zero result, C is the adder carry-out, and V is two's-complement overflow.
- R8: When a logical or move form updates the flags: N and Z come from the result, C comes from shift_cout, and V keeps flags_in[0].
- R9: With OUT_REG=1, the outputs change only at a rising clock edge and reflect the inputs present before that edge. An active-low reset clears result, wr_en and flags_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand, already shifted |
| opcode | input | 4 | Operation code (encoding in R1) |
| set_flags | input | 1 | Requests a flag update for ordinary opcodes |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_cout | input | 1 | Carry-out of the shift stage |
| result | output | DATA_W | Computed value |
| wr_en | output | 1 | Destination write request |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest cases to reach are the ones where two carry sources meet. In SBC and RSC, the incoming carry turns into a borrow, and the outgoing carry has to mean "no borrow". At the signed boundaries, overflow and carry must be reported independently of each other. The vector table pairs each with-carry subtraction with both values of the incoming C. It also drives operands at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, so that C and V each appear both alone and together. For the logical forms, the incoming V is set to 1, and shift_cout is set to a value the adder would not produce, so a wrong flag source shows up at the ports.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } dp_op_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   // Flag-only forms occupy opcodes 8..11
   function automatic logic op_is_flag_only(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   function automatic logic op_is_arith(input logic [3:0] op);
      return (op[3:2] == 2'b00 && op[1]) || op[3:2] == 2'b01 ||
             op == OP_CMP || op == OP_CMN;
   endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [3:0]        op,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic              swap, invert, carry;
   logic [DATA_W-1:0] x, y;

   always_comb begin
      swap   = (op == OP_RSB) || (op == OP_RSC);
      invert = (op == OP_SUB) || (op == OP_SBC) || swap || (op == OP_CMP);
      unique case (op)
         OP_ADC, OP_SBC, OP_RSC: carry = cin;
         OP_SUB, OP_RSB, OP_CMP: carry = 1'b1;
         default:                carry = 1'b0;
      endcase
      x = swap ? b : a;
      y = swap ? a : b;
      if (invert) y = ~y;
      {cout, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, carry};
      ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
   end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [3:0]        op,
   output logic [DATA_W-1:0] res
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_BIC:         res = a & ~b;
         OP_MOV:         res = b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end
endmodule

// File: rtl/dp_alu_flagsel.sv
module dp_alu_flagsel
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op,
   input  logic              set_flags,
   input  logic [3:0]        flags_in,
   input  logic [DATA_W-1:0] arith_res,
   input  logic              arith_cout,
   input  logic              arith_ovf,
   input  logic [DATA_W-1:0] logic_res,
   input  logic              shift_cout,
   output logic [DATA_W-1:0] res,
   output logic              wr,
   output logic [3:0]        flags
);
   logic arith, update;

   always_comb begin
      arith  = op_is_arith(op);
      update = set_flags || op_is_flag_only(op);
      wr     = !op_is_flag_only(op);
      res    = arith ? arith_res : logic_res;
      flags  = flags_in;
      if (update) begin
         flags[FLG_N] = res[DATA_W-1];
         flags[FLG_Z] = (res == '0);
         flags[FLG_C] = arith ? arith_cout : shift_cout;
         if (arith) flags[FLG_V] = arith_ovf;
      end
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        opcode,
   input  logic              set_flags,
   input  logic [3:0]        flags_in,
   input  logic              shift_cout,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic [3:0]        flags_out
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sum_w, lres_w, res_w;
   logic              cout_w, ovf_w, wr_w;
   logic [3:0]        flg_w;

   dp_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(op_a), .b(op_b), .op(opcode), .cin(flags_in[FLG_C]),
      .sum(sum_w), .cout(cout_w), .ovf(ovf_w)
   );

   dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a(op_a), .b(op_b), .op(opcode), .res(lres_w)
   );

   dp_alu_flagsel #(.DATA_W(DATA_W)) u_flagsel (
      .op(opcode), .set_flags(set_flags), .flags_in(flags_in),
      .arith_res(sum_w), .arith_cout(cout_w), .arith_ovf(ovf_w),
      .logic_res(lres_w), .shift_cout(shift_cout),
      .res(res_w), .wr(wr_w), .flags(flg_w)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result    <= '0;
            wr_en     <= 1'b0;
            flags_out <= '0;
         end else begin
            result    <= res_w;
            wr_en     <= wr_w;
            flags_out <= flg_w;
         end
      end
   end else begin : g_comb
      assign result    = res_w;
      assign wr_en     = wr_w;
      assign flags_out = flg_w;
   end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
   import dp_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [3:0]        opcode,
   input logic              set_flags,
   input logic [3:0]        flags_in,
   input logic              shift_cout,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [3:0]        flags_out
);
   logic              vld;
   logic [DATA_W-1:0] c_a, c_b;
   logic [3:0]        c_op, c_fl;
   logic              c_s, c_sh;

   if (OUT_REG) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= 1'b0; c_a <= '0; c_b <= '0; c_op <= '0;
            c_fl <= '0; c_s <= 1'b0; c_sh <= 1'b0;
         end else begin
            vld <= 1'b1; c_a <= op_a; c_b <= op_b; c_op <= opcode;
            c_fl <= flags_in; c_s <= set_flags; c_sh <= shift_cout;
         end
      end
   end else begin : g_pass
      assign vld = 1'b1;
      assign c_a = op_a;   assign c_b = op_b;   assign c_op = opcode;
      assign c_fl = flags_in; assign c_s = set_flags; assign c_sh = shift_cout;
   end

   logic c_fo, c_ar, c_upd;
   assign c_fo  = op_is_flag_only(c_op);
   assign c_ar  = op_is_arith(c_op);
   assign c_upd = c_s || c_fo;

   p_flag_only_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fo) |-> !wr_en);
   p_ordinary_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !c_fo) |-> wr_en);
   p_flags_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !c_upd) |-> (flags_out == c_fl));
   p_nz_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_upd) |-> (flags_out[FLG_N] == result[DATA_W-1] &&
                          flags_out[FLG_Z] == (result == '0)));
   p_logic_carry_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_upd && !c_ar) |-> (flags_out[FLG_C] == c_sh &&
                                   flags_out[FLG_V] == c_fl[FLG_V]));
   p_mov_copies_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_op == OP_MOV) |-> (result == c_b));
   p_and_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_op == OP_AND) |-> (result == (c_a & c_b)));
endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
   .set_flags(set_flags), .flags_in(flags_in), .shift_cout(shift_cout),
   .result(result), .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0;
   logic [3:0]    opcode = '0, flags_in = '0;
   logic          set_flags = 1'b0, shift_cout = 1'b0;
   logic [W-1:0]  result;
   logic          wr_en;
   logic [3:0]    flags_out;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dp_alu u_dp_alu (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .set_flags(set_flags), .flags_in(flags_in), .shift_cout(shift_cout),
      .result(result), .wr_en(wr_en), .flags_out(flags_out)
   );

   // Fields: op, s, flags_in{N,Z,C,V}, shift_cout, a, b, exp result, exp wr_en, exp flags, requirement
   localparam int VW = 4+1+4+1+32+32+32+1+4+4;
   localparam int NV = 25;
   localparam logic [VW-1:0] VEC [NV] = '{
      {4'h4,1'b1,4'b0000,1'b0,32'h1,32'h2,32'h3,1'b1,4'b0000,4'd1},                      // R1 add
      {4'h5,1'b1,4'b0010,1'b0,32'h5,32'h6,32'hC,1'b1,4'b0000,4'd1},                      // R1 adc C=1
      {4'h5,1'b1,4'b0010,1'b0,32'hFFFFFFFF,32'h0,32'h0,1'b1,4'b0110,4'd1},               // R1 adc wrap
      {4'h2,1'b1,4'b0000,1'b0,32'h5,32'h3,32'h2,1'b1,4'b0010,4'd2},                      // R2 no borrow
      {4'h2,1'b1,4'b0000,1'b0,32'h3,32'h5,32'hFFFFFFFE,1'b1,4'b1000,4'd2},               // R2 borrow
      {4'h6,1'b1,4'b0000,1'b0,32'hA,32'h3,32'h6,1'b1,4'b0010,4'd2},                      // R2 sbc C=0
      {4'h6,1'b1,4'b0010,1'b0,32'hA,32'h3,32'h7,1'b1,4'b0010,4'd2},                      // R2 sbc C=1
      {4'h3,1'b1,4'b0000,1'b0,32'h3,32'hA,32'h7,1'b1,4'b0010,4'd3},                      // R3 rsb
      {4'h7,1'b1,4'b0000,1'b0,32'h3,32'hA,32'h6,1'b1,4'b0010,4'd3},                      // R3 rsc C=0
      {4'h7,1'b1,4'b0010,1'b0,32'h3,32'hA,32'h7,1'b1,4'b0010,4'd3},                      // R3 rsc C=1
      {4'h3,1'b1,4'b0000,1'b0,32'h0,32'h0,32'h0,1'b1,4'b0110,4'd3},                      // R3 0-0
      {4'h4,1'b1,4'b0000,1'b0,32'h7FFFFFFF,32'h1,32'h80000000,1'b1,4'b1001,4'd7},        // R7 V only
      {4'h4,1'b1,4'b0000,1'b0,32'hFFFFFFFF,32'h1,32'h0,1'b1,4'b0110,4'd7},               // R7 C only
      {4'h2,1'b1,4'b0000,1'b0,32'h80000000,32'h1,32'h7FFFFFFF,1'b1,4'b0011,4'd7},        // R7 C and V
      {4'h0,1'b1,4'b0001,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'hF000F000,1'b1,4'b1011,4'd8}, // R8 and
      {4'h1,1'b1,4'b1111,1'b0,32'hFFFF0000,32'hFFFF0000,32'h0,1'b1,4'b0101,4'd8},        // R8 eor
      {4'hE,1'b1,4'b0000,1'b0,32'hFF,32'h0F,32'hF0,1'b1,4'b0000,4'd4},                   // R4 bic
      {4'hD,1'b0,4'b0110,1'b0,32'hDEADBEEF,32'h12345678,32'h12345678,1'b1,4'b0110,4'd4}, // R4 mov ignores a
      {4'hF,1'b1,4'b0000,1'b1,32'hDEADBEEF,32'h0,32'hFFFFFFFF,1'b1,4'b1010,4'd4},        // R4 mvn
      {4'hC,1'b0,4'b1010,1'b1,32'h0F,32'hF0,32'hFF,1'b1,4'b1010,4'd6},                   // R6 orr S=0
      {4'h4,1'b0,4'b1111,1'b0,32'h1,32'h1,32'h2,1'b1,4'b1111,4'd6},                      // R6 add S=0
      {4'hA,1'b0,4'b0000,1'b0,32'h5,32'h5,32'h0,1'b0,4'b0110,4'd5},                      // R5 cmp
      {4'hB,1'b0,4'b0000,1'b0,32'hFFFFFFFF,32'h1,32'h0,1'b0,4'b0110,4'd5},               // R5 cmn
      {4'h8,1'b0,4'b0001,1'b0,32'hF0,32'h0F,32'h0,1'b0,4'b0101,4'd5},                    // R5 tst
      {4'h9,1'b0,4'b0000,1'b1,32'h80000000,32'h0,32'h80000000,1'b0,4'b1010,4'd5}         // R5 teq
   };

   task automatic check(input string req, input string what,
                        input logic [W-1:0] got, input logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic s, input logic [3:0] fi,
                        input logic sh, input logic [W-1:0] a, input logic [W-1:0] b);
      opcode = op; set_flags = s; flags_in = fi; shift_cout = sh; op_a = a; op_b = b;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", "reset result", result, '0);
      check("R9", "reset wr_en", {31'b0, wr_en}, '0);
      check("R9", "reset flags", {28'b0, flags_out}, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         string rq;
         v = VEC[i];
         @(negedge clk);
         drive(v[114:111], v[110], v[109:106], v[105], v[104:73], v[72:41]);
         @(negedge clk);
         rq = $sformatf("R%0d", v[3:0]);
         check(rq, $sformatf("vec%0d result", i), result, v[40:9]);
         check(rq, $sformatf("vec%0d wr_en", i), {31'b0, wr_en}, {31'b0, v[8]});
         check(rq, $sformatf("vec%0d flags", i), {28'b0, flags_out}, {28'b0, v[7:4]});
      end

      // R9 latency: new inputs do not show before the edge
      @(negedge clk);
      drive(4'h4, 1'b1, 4'b0000, 1'b0, 32'h10, 32'h20);
      @(negedge clk);
      drive(4'h2, 1'b1, 4'b0000, 1'b0, 32'h100, 32'h1);
      #2;
      check("R9", "held before edge", result, 32'h30);
      @(negedge clk);
      check("R9", "after edge", result, 32'hFF);

      // R9 reset clears outputs mid-run
      rst_n = 1'b0;
      #1;
      check("R9", "async reset result", result, '0);
      check("R9", "async reset flags", {28'b0, flags_out}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 flag-only form with set_flags=1 still suppresses write
      drive(4'hA, 1'b1, 4'b1111, 1'b0, 32'h3, 32'h5);
      @(negedge clk);
      check("R5", "cmp S=1 wr_en", {31'b0, wr_en}, '0);
      check("R5", "cmp S=1 flags", {28'b0, flags_out}, {28'b0, 4'b1000});

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule